// File: doc/BRIEF.md
# Nanostore-Decoded 16-bit DSP Execution Unit

This block is one arithmetic execution unit in a reconfigurable signal-processing cluster. A controller broadcasts a 3-bit operation code to every unit each cycle. Each unit turns that code into its own wide control word by looking it up in a small local store of eight 53-bit microwords. The same broadcast code can therefore mean a different operation in every unit.

The store is filled bit-serially during a setup phase. After the setup phase ends, a one-cycle commit pulse starts execution. Each of the two operands comes from a crossbar input. It passes through its own six-entry register file, which can act as addressed storage or as a shift chain that retimes the stream. The 16-bit ALU adds, subtracts, accumulates, compares, selects the larger or smaller operand and shifts right. It also reports whether operand a exceeds operand b. Its result can be taken straight from the ALU or through an output register.

A carry input and a carry output let two units form one 32-bit adder. The carry output of the low unit feeds the carry input of the high unit.

Top module: `dspeu_top`

## Requirements
- R1: After reset, and from any cycle with `cfg_shift_en` high until the cycle after a `cfg_commit` pulse, the unit is idle. While idle, `result`, `a_gt_b` and `carry_out` are 0, and no register file, accumulator or output register changes.
- R2: Each cycle with `cfg_shift_en` high shifts `cfg_data` into the store. A full load is 424 bits: microword 7 goes first and microword 0 last, each sent most significant bit first. While running, `gop` selects the microword.
- R2 (microword layout): the microword fields, from bit 0 upward, are:
  - op [2:0]
  - signed [3]
  - shift amount [7:4]
  - A read address [10:8]
  - A write address [13:11]
  - B read address [16:14]
  - B write address [19:17]
  - A write enable [20]
  - B write enable [21]
  - A delay mode [22]
  - B delay mode [23]
  - output register enable [24]
  - accumulator clear [25]
  - carry-in enable [26]
  - Bits [52:27] are unused.
- R3: With op 0 (add), the result is a + b + c. With op 1 (subtract), the result is a + ~b + c. Here c is `carry_in` when carry-in enable is set; otherwise c is 0 for add and 1 for subtract. `carry_out` is the carry from bit 15 for these two ops and 0 for all other ops. `carry_out` is never registered.
- R4: `a_gt_b` is 1 when a > b. The comparison is two's complement when the signed bit is set and unsigned when it is clear. Op 3 passes a to the result and op 7 passes b.
- R5: Op 4 returns the larger of a and b and op 5 the smaller, using the same signedness as R4.
- R6: Op 6 shifts a right by the shift amount (0 to 15). The shift is arithmetic when signed and logical otherwise.
- R7: Op 2 returns acc + a and stores that value in the accumulator. When the clear bit is set, acc counts as 0 for that cycle. With any other op, the clear bit zeroes the accumulator at the clock edge.
- R8: A read address of 0 to 5 selects that register; 6 or 7 selects the crossbar input directly. A register is written at the clock edge only when its file's write enable is set and the write address matches. Otherwise the register holds its value.
- R9: In delay mode, each edge moves the input into register 0 and moves register i into register i+1. Reading address k then yields the input from k+1 cycles earlier.
- R10: When the output register enable is set, `result` and `a_gt_b` show the ALU values of the previous running cycle. When it is clear, they follow the ALU in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_shift_en | input | 1 | Shift `cfg_data` into the store; stops execution |
| cfg_data | input | 1 | Serial configuration bit |
| cfg_commit | input | 1 | One-cycle pulse that starts execution |
| gop | input | 3 | Broadcast instruction, selects a microword |
| opnd_a | input | 16 | Operand A from the crossbar |
| opnd_b | input | 16 | Operand B from the crossbar |
| carry_in | input | 1 | Carry from the paired lower unit |
| result | output | 16 | Unit data output |
| a_gt_b | output | 1 | Status flag, a greater than b |
| carry_out | output | 1 | Carry to the paired upper unit |

## Verification
The hardest states to reach from the ports are the contents of the register files. They are visible only by running a microword whose read address points at them. So the bench loads a second nanostore with dedicated write-only, read-only and delay-mode words. It writes a register, runs a non-writing word, and then reads the register back. It streams a known sequence through the delay chain and checks the output three cycles late. The same reload places the idle window from R1 between two running phases.

// File: rtl/dspeu_pkg.sv
package dspeu_pkg;
    localparam int DW    = 16;
    localparam int NREG  = 6;
    localparam int NWORD = 8;
    localparam int AW    = 3;
    localparam int UW    = 53;
    localparam int SW    = $clog2(DW);
    localparam int SELW  = $clog2(NWORD);
    localparam int USED  = 3 + 1 + SW + 4 * AW + 7;
    localparam int RSV   = UW - USED;

    typedef enum logic [2:0] {
        OP_ADD = 3'd0, OP_SUB = 3'd1, OP_ACC = 3'd2, OP_CMP = 3'd3,
        OP_MAX = 3'd4, OP_MIN = 3'd5, OP_SHR = 3'd6, OP_PASSB = 3'd7
    } op_e;

    typedef struct packed {
        logic [RSV-1:0] rsv;
        logic           cin_en;
        logic           acc_clr;
        logic           oreg_en;
        logic           b_dly;
        logic           a_dly;
        logic           b_we;
        logic           a_we;
        logic [AW-1:0]  b_wr;
        logic [AW-1:0]  b_rd;
        logic [AW-1:0]  a_wr;
        logic [AW-1:0]  a_rd;
        logic [SW-1:0]  shamt;
        logic           sgn;
        op_e            op;
    } uword_t;
endpackage

// File: rtl/dspeu_nanostore.sv
module dspeu_nanostore #(
    parameter int W = dspeu_pkg::UW,
    parameter int N = dspeu_pkg::NWORD
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load_en,
    input  logic                 load_bit,
    input  logic [$clog2(N)-1:0] sel,
    output logic [W-1:0]         word
);
    localparam int TOT = N * W;

    logic [TOT-1:0] store_d, store_q;

    always_comb begin
        store_d = store_q;
        if (load_en) store_d = {store_q[TOT-2:0], load_bit};
        word = store_q[int'(sel) * W +: W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) store_q <= '0;
        else        store_q <= store_d;
    end

    // R2: contents change only while shifting
    assert_store_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !load_en |=> $stable(store_q));
endmodule

// File: rtl/dspeu_regfile.sv
module dspeu_regfile #(
    parameter int DW   = dspeu_pkg::DW,
    parameter int NREG = dspeu_pkg::NREG,
    parameter int AW   = dspeu_pkg::AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          we,
    input  logic          dly,
    input  logic [AW-1:0] wr_addr,
    input  logic [AW-1:0] rd_addr,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout
);
    localparam logic [AW-1:0] NR = AW'(NREG);

    logic [DW-1:0] rf_d [NREG];
    logic [DW-1:0] rf_q [NREG];

    always_comb begin
        for (int i = 0; i < NREG; i++) rf_d[i] = rf_q[i];
        if (en) begin
            if (dly) begin
                rf_d[0] = din;
                for (int i = 1; i < NREG; i++) rf_d[i] = rf_q[i-1];
            end else if (we && wr_addr < NR) begin
                rf_d[wr_addr] = din;
            end
        end
        dout = (rd_addr < NR) ? rf_q[rd_addr] : din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) rf_q[i] <= '0;
        end else begin
            for (int i = 0; i < NREG; i++) rf_q[i] <= rf_d[i];
        end
    end

    // R9: delay mode feeds the chain head from the input
    assert_delay_head_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (en && dly) |=> rf_q[0] == $past(din));

    for (genvar g = 0; g < NREG; g++) begin : g_chk
        // R8: an entry not targeted this cycle keeps its value
        assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
            !(en && (dly || (we && wr_addr == AW'(g)))) |=> $stable(rf_q[g]));
        if (g > 0) begin : g_link
            // R9: each stage takes its predecessor
            assert_delay_link_R9: assert property (@(posedge clk) disable iff (!rst_n)
                (en && dly) |=> rf_q[g] == $past(rf_q[g-1]));
        end
    end
endmodule

// File: rtl/dspeu_alu.sv
module dspeu_alu
    import dspeu_pkg::*;
(
    input  op_e           op,
    input  logic          sgn,
    input  logic [SW-1:0] shamt,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic [DW-1:0] acc,
    input  logic          cin,
    input  logic          cin_en,
    output logic [DW-1:0] res,
    output logic          cout,
    output logic          gt
);
    logic [DW-1:0] stg [SW+1];
    logic          fill;

    assign fill   = sgn & a[DW-1];
    assign stg[0] = a;

    for (genvar k = 0; k < SW; k++) begin : g_shift
        assign stg[k+1] = shamt[k] ? {{(1 << k){fill}}, stg[k][DW-1:(1 << k)]} : stg[k];
    end

    logic          cin_eff;
    logic [DW-1:0] bb;
    logic [DW:0]   sum;

    always_comb begin
        cin_eff = cin_en ? cin : (op == OP_SUB);
        bb      = (op == OP_SUB) ? ~b : b;
        sum     = {1'b0, a} + {1'b0, bb} + {{DW{1'b0}}, cin_eff};
        gt      = sgn ? ($signed(a) > $signed(b)) : (a > b);
        cout    = 1'b0;
        unique case (op)
            OP_ADD, OP_SUB: begin
                res  = sum[DW-1:0];
                cout = sum[DW];
            end
            OP_ACC:   res = acc + a;
            OP_CMP:   res = a;
            OP_MAX:   res = gt ? a : b;
            OP_MIN:   res = gt ? b : a;
            OP_SHR:   res = stg[SW];
            default:  res = b;
        endcase
    end
endmodule

// File: rtl/dspeu_top.sv
module dspeu_top
    import dspeu_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_shift_en,
    input  logic          cfg_data,
    input  logic          cfg_commit,
    input  logic [2:0]    gop,
    input  logic [15:0]   opnd_a,
    input  logic [15:0]   opnd_b,
    input  logic          carry_in,
    output logic [15:0]   result,
    output logic          a_gt_b,
    output logic          carry_out
);
    typedef struct packed {
        logic          run;
        logic [DW-1:0] acc;
        logic [DW-1:0] out;
        logic          flag;
    } st_t;

    st_t           st_d, st_q;
    logic [UW-1:0] word;
    uword_t        uw;
    logic [DW-1:0] opa, opb, acc_base, alu_res;
    logic          alu_cout, alu_gt;
    logic          unused_rsv;

    assign uw         = uword_t'(word);
    assign unused_rsv = ^uw.rsv;
    assign acc_base   = uw.acc_clr ? '0 : st_q.acc;

    dspeu_nanostore #(.W(UW), .N(NWORD)) u_store (
        .clk(clk), .rst_n(rst_n), .load_en(cfg_shift_en), .load_bit(cfg_data),
        .sel(gop[SELW-1:0]), .word(word)
    );

    dspeu_regfile #(.DW(DW), .NREG(NREG), .AW(AW)) u_rfa (
        .clk(clk), .rst_n(rst_n), .en(st_q.run), .we(uw.a_we), .dly(uw.a_dly),
        .wr_addr(uw.a_wr), .rd_addr(uw.a_rd), .din(opnd_a), .dout(opa)
    );

    dspeu_regfile #(.DW(DW), .NREG(NREG), .AW(AW)) u_rfb (
        .clk(clk), .rst_n(rst_n), .en(st_q.run), .we(uw.b_we), .dly(uw.b_dly),
        .wr_addr(uw.b_wr), .rd_addr(uw.b_rd), .din(opnd_b), .dout(opb)
    );

    dspeu_alu u_alu (
        .op(uw.op), .sgn(uw.sgn), .shamt(uw.shamt), .a(opa), .b(opb),
        .acc(acc_base), .cin(carry_in), .cin_en(uw.cin_en),
        .res(alu_res), .cout(alu_cout), .gt(alu_gt)
    );

    always_comb begin
        st_d = st_q;
        if (cfg_shift_en)    st_d.run = 1'b0;
        else if (cfg_commit) st_d.run = 1'b1;
        if (st_q.run) begin
            if (uw.op == OP_ACC)  st_d.acc = alu_res;
            else if (uw.acc_clr)  st_d.acc = '0;
            st_d.out  = alu_res;
            st_d.flag = alu_gt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        result    = '0;
        a_gt_b    = 1'b0;
        carry_out = 1'b0;
        if (st_q.run) begin
            result    = uw.oreg_en ? st_q.out  : alu_res;
            a_gt_b    = uw.oreg_en ? st_q.flag : alu_gt;
            carry_out = alu_cout;
        end
    end

    // R1: idle unit drives nothing
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.run |-> (result == '0 && !a_gt_b && !carry_out));
    // R5: unsigned max never below either operand
    assert_max_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.run && uw.op == OP_MAX && !uw.sgn) |-> (alu_res >= opa && alu_res >= opb));
    // R7: clear without accumulate leaves zero
    assert_acc_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.run && uw.acc_clr && uw.op != OP_ACC) |=> st_q.acc == '0);
    // R10: registered output lags the ALU by one cycle
    assert_oreg_lag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.run && uw.oreg_en) ##1 (st_q.run && uw.oreg_en) |-> result == $past(alu_res));
endmodule

// File: tb/sim_dspeu_top.sv
module sim_dspeu_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_shift_en = 1'b0, cfg_data = 1'b0, cfg_commit = 1'b0;
    logic [2:0]  gop = '0;
    logic [15:0] opnd_a = '0, opnd_b = '0;
    logic        carry_in = 1'b0;
    logic [15:0] result;
    logic        a_gt_b, carry_out;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dspeu_top u0 (
        .clk(clk), .rst_n(rst_n), .cfg_shift_en(cfg_shift_en), .cfg_data(cfg_data),
        .cfg_commit(cfg_commit), .gop(gop), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .carry_in(carry_in), .result(result), .a_gt_b(a_gt_b), .carry_out(carry_out)
    );

    typedef struct packed {
        logic [2:0]  ins;
        logic [15:0] a;
        logic [15:0] b;
        logic        ci;
        logic [15:0] eo;
        logic        ef;
        logic        ec;
    } vec_t;

    localparam vec_t TV [14] = '{
        '{3'd0, 16'h1234, 16'h0FF0, 1'b0, 16'h2224, 1'b1, 1'b0},
        '{3'd0, 16'hFFFF, 16'h0001, 1'b1, 16'h0001, 1'b1, 1'b1},
        '{3'd1, 16'h0005, 16'h0007, 1'b0, 16'hFFFE, 1'b0, 1'b0},
        '{3'd1, 16'h8000, 16'h0001, 1'b0, 16'h7FFF, 1'b1, 1'b1},
        '{3'd2, 16'h8000, 16'h0001, 1'b0, 16'h0001, 1'b0, 1'b0},
        '{3'd2, 16'h0005, 16'hFFFF, 1'b0, 16'h0005, 1'b1, 1'b0},
        '{3'd3, 16'h8000, 16'h0001, 1'b0, 16'h0001, 1'b1, 1'b0},
        '{3'd3, 16'h0003, 16'h0009, 1'b0, 16'h0003, 1'b0, 1'b0},
        '{3'd4, 16'h8F00, 16'h0000, 1'b0, 16'hF8F0, 1'b0, 1'b0},
        '{3'd4, 16'h7F00, 16'h0000, 1'b0, 16'h07F0, 1'b1, 1'b0},
        '{3'd5, 16'h0010, 16'h0000, 1'b0, 16'h0010, 1'b1, 1'b0},
        '{3'd6, 16'h0020, 16'h0000, 1'b0, 16'h0030, 1'b1, 1'b0},
        '{3'd6, 16'hFFF0, 16'h0000, 1'b0, 16'h0020, 1'b1, 1'b0},
        '{3'd5, 16'h0001, 16'h0000, 1'b0, 16'h0001, 1'b1, 1'b0}
    };

    logic [52:0] img [8];

    function automatic logic [52:0] mk(int op, int sg, int sh, int ard, int awr, int brd,
                                       int bwr, int awe, int bwe, int adl, int bdl,
                                       int oreg, int clr, int cen);
        logic [52:0] w = '0;
        w[2:0]   = op[2:0];
        w[3]     = sg[0];
        w[7:4]   = sh[3:0];
        w[10:8]  = ard[2:0];
        w[13:11] = awr[2:0];
        w[16:14] = brd[2:0];
        w[19:17] = bwr[2:0];
        w[20]    = awe[0];
        w[21]    = bwe[0];
        w[22]    = adl[0];
        w[23]    = bdl[0];
        w[24]    = oreg[0];
        w[25]    = clr[0];
        w[26]    = cen[0];
        return w;
    endfunction

    task automatic chk(string req, string what, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic string tag(logic [2:0] ins);
        case (ins)
            3'd0, 3'd1: return "R3";
            3'd2, 3'd3: return "R5";
            3'd4:       return "R6";
            default:    return "R7";
        endcase
    endfunction

    // R2: word 7 first, MSB first; idle outputs checked during shifting (R1)
    task automatic load_store();
        @(negedge clk);
        cfg_shift_en = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            for (int k = 52; k >= 0; k--) begin
                cfg_data = img[i][k];
                @(negedge clk);
            end
        end
        cfg_shift_en = 1'b0;
        opnd_a = 16'h7777; opnd_b = 16'h0001;
        #1 chk("R1", "result while loading", result, 16'h0000);
        cfg_commit = 1'b1;
        @(negedge clk);
        cfg_commit = 1'b0;
    endtask

    task automatic step(logic [2:0] ins, logic [15:0] a, logic [15:0] b, logic ci);
        @(negedge clk);
        gop = ins; opnd_a = a; opnd_b = b; carry_in = ci;
        #1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        opnd_a = 16'h00FF; opnd_b = 16'h0001; carry_in = 1'b1;
        #1;
        chk("R1", "reset result", result, 16'h0000);
        chk("R1", "reset flag", {15'd0, a_gt_b}, 16'h0000);
        chk("R1", "reset carry", {15'd0, carry_out}, 16'h0000);
        rst_n = 1'b1;
        @(negedge clk);
        #1 chk("R1", "before commit", result, 16'h0000);

        img[0] = mk(0, 0, 0, 7, 0, 7, 0, 0, 0, 0, 0, 0, 0, 1);
        img[1] = mk(1, 0, 0, 7, 0, 7, 0, 0, 0, 0, 0, 0, 0, 0);
        img[2] = mk(4, 1, 0, 7, 0, 7, 0, 0, 0, 0, 0, 0, 0, 0);
        img[3] = mk(5, 0, 0, 7, 0, 7, 0, 0, 0, 0, 0, 0, 0, 0);
        img[4] = mk(6, 1, 4, 7, 0, 7, 0, 0, 0, 0, 0, 0, 0, 0);
        img[5] = mk(2, 0, 0, 7, 0, 7, 0, 0, 0, 0, 0, 0, 1, 0);
        img[6] = mk(2, 0, 0, 7, 0, 7, 0, 0, 0, 0, 0, 0, 0, 0);
        img[7] = mk(7, 0, 0, 7, 0, 7, 0, 0, 0, 0, 0, 0, 0, 0);
        load_store();

        for (int i = 0; i < 14; i++) begin
            step(TV[i].ins, TV[i].a, TV[i].b, TV[i].ci);
            chk(tag(TV[i].ins), $sformatf("R2 vector %0d result", i), result, TV[i].eo);
            chk("R4", $sformatf("vector %0d flag", i), {15'd0, a_gt_b}, {15'd0, TV[i].ef});
            chk("R3", $sformatf("vector %0d carry", i), {15'd0, carry_out}, {15'd0, TV[i].ec});
        end
        step(3'd7, 16'h1111, 16'h2222, 1'b0);
        chk("R4", "pass b", result, 16'h2222);

        img[0] = mk(3, 0, 0, 2, 0, 7, 0, 0, 0, 1, 0, 0, 0, 0);
        img[1] = mk(3, 0, 0, 7, 4, 7, 0, 1, 0, 0, 0, 0, 0, 0);
        img[2] = mk(3, 0, 0, 4, 0, 7, 0, 0, 0, 0, 0, 0, 0, 0);
        img[3] = mk(0, 0, 0, 7, 0, 7, 0, 0, 0, 0, 0, 1, 0, 0);
        img[4] = mk(0, 0, 0, 7, 0, 7, 0, 0, 0, 0, 0, 0, 0, 0);
        img[5] = '0; img[6] = '0; img[7] = '0;
        load_store();

        step(3'd1, 16'hBEEF, 16'h0000, 1'b0);
        chk("R8", "bypass while writing", result, 16'hBEEF);
        step(3'd2, 16'h0000, 16'h0000, 1'b0);
        chk("R8", "read register 4", result, 16'hBEEF);
        step(3'd4, 16'h0001, 16'h0001, 1'b1);
        chk("R3", "carry-in ignored", result, 16'h0002);
        step(3'd2, 16'h0000, 16'h0000, 1'b0);
        chk("R8", "register 4 held", result, 16'hBEEF);

        step(3'd3, 16'h0100, 16'h0002, 1'b0);
        step(3'd3, 16'h0200, 16'h0002, 1'b0);
        chk("R10", "registered result", result, 16'h0102);
        step(3'd3, 16'h0000, 16'h0000, 1'b0);
        chk("R10", "registered result next", result, 16'h0202);
        step(3'd4, 16'h0005, 16'h0000, 1'b0);
        chk("R10", "bypassed result", result, 16'h0005);

        step(3'd0, 16'h0011, 16'h0030, 1'b0);
        step(3'd0, 16'h0022, 16'h0030, 1'b0);
        step(3'd0, 16'h0033, 16'h0030, 1'b0);
        step(3'd0, 16'h0044, 16'h0030, 1'b0);
        chk("R9", "delay tap 1", result, 16'h0011);
        step(3'd0, 16'h0055, 16'h0030, 1'b0);
        chk("R9", "delay tap 2", result, 16'h0022);
        step(3'd0, 16'h0066, 16'h0030, 1'b0);
        chk("R9", "delay tap 3", result, 16'h0033);
        chk("R9", "delayed flag", {15'd0, a_gt_b}, 16'h0001);

        @(negedge clk);
        cfg_shift_en = 1'b1;
        @(negedge clk);
        cfg_shift_en = 1'b0;
        gop = 3'd4; opnd_a = 16'h0007; opnd_b = 16'hFFFF; carry_in = 1'b0;
        #1;
        chk("R1", "stopped result", result, 16'h0000);
        chk("R1", "stopped carry", {15'd0, carry_out}, 16'h0000);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule